// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter with Phase Decoder

This block is a four-stage twisted-ring (Johnson) counter. The first stage takes in the inverted value of the last stage, and the remaining stages pass their contents one place down the chain. Starting from all zeros, the chain fills with ones and then empties again, so the counter steps through eight states. Each step changes exactly one stage. Because of this, every state can be recognised with a single two-input AND gate without glitches, and the block drives eight one-hot phase lines from such gates. It is meant for sequencing control steps where hazard-free strobes matter.

A register upset or a wrong preset can leave the chain holding a pattern that is outside the eight-state cycle. To recover, a correction path watches for the pattern where the first and last stages are both low. When it sees that pattern, it loads the state that has only the first stage set. This load agrees with the normal successor of the all-zero state, so the legal cycle is undisturbed, and every illegal pattern is back in the cycle within three clocks. The value loaded by the synchronous reset is a parameter, `START`, which defaults to all zeros.

Top module: `jc_twisted_ring`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next stage value is `START` (default 0000). `stage_q[0]` is the first stage (Qa) and `stage_q[3]` is the last stage (Qd).
- R2: When neither reset nor correction applies, the first stage takes the complement of the last stage and each stage i>0 takes the old value of stage i-1.
- R3: Written as Qa Qb Qc Qd, the normal cycle from 0000 is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, and then back to 0000. Its modulus is 8.
- R4: Any two consecutive states in the normal cycle differ in exactly one stage.
- R5: When Qa=0 and Qd=0 and reset is low, the next state is Qa=1 with Qb=Qc=Qd=0 (`stage_q` = 4'b0001).
- R6: From any starting value, the counter is in the normal cycle after at most three clocks and then stays in it.
- R7: Bit k of `phase_hot` is high for the k-th state of the R3 cycle (k = 0..7). Each bit is a two-input AND: k0 = !Qa&!Qd, k1 = Qa&!Qb, k2 = Qb&!Qc, k3 = Qc&!Qd, k4 = Qa&Qd, k5 = !Qa&Qb, k6 = !Qb&Qc, k7 = !Qc&Qd.
- R8: In every state of the normal cycle, exactly one bit of `phase_hot` is high.
- R9: Reset takes priority over both shifting and correction in any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads `START` |
| stage_q | output | 4 | Stage outputs, bit 0 = first stage |
| phase_hot | output | 8 | One-hot decoded phase of the cycle |

## Verification
The hard case is an illegal pattern: the ports cannot put the counter into one, because reset only ever loads a legal value. The bench therefore elaborates sixteen extra copies of the block, one with `START` set to each of the sixteen patterns. All copies share the clock and a reset that pulses at random. Every recovery path is therefore exercised over and over and checked against a bench model: 1011 takes three steps, 0100 takes one, and 0110 is caught directly. The main instance follows the legal cycle and is checked against a phase table.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int unsigned JC_N = 4;
  localparam int unsigned JC_PHASES = 2 * JC_N;

  typedef logic [JC_N-1:0] ring_t;
  typedef logic [JC_PHASES-1:0] phase_t;

  // twisted shift: stage 0 gets inverted last stage, others move down
  function automatic ring_t twist_shift(input ring_t q);
    return {q[JC_N-2:0], ~q[JC_N-1]};
  endfunction

  // correction trigger: first and last stages both low
  function automatic logic trap_hit(input ring_t q);
    return ~q[0] & ~q[JC_N-1];
  endfunction

  // state loaded on a trap: successor of all-zero
  function automatic ring_t entry_state();
    return ring_t'(1);
  endfunction

  // true when q lies on the 2N-state cycle from zero
  function automatic logic in_cycle(input ring_t q);
    ring_t walk;
    logic hit;
    walk = '0;
    hit = 1'b0;
    for (int k = 0; k < int'(JC_PHASES); k++) begin
      if (walk == q) hit = 1'b1;
      walk = twist_shift(walk);
    end
    return hit;
  endfunction
endpackage

// File: rtl/jc_stage_chain.sv
module jc_stage_chain
  import jc_pkg::*;
#(
  parameter ring_t START = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load_en,
  input  ring_t load_val,
  output ring_t q
);
  ring_t nxt;

  always_comb begin
    if (load_en) nxt = load_val;
    else         nxt = twist_shift(q);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= START;
    else     q <= nxt;
  end
endmodule

// File: rtl/jc_trap_detect.sv
module jc_trap_detect
  import jc_pkg::*;
(
  input  ring_t q,
  output logic  trap,
  output ring_t fix_val
);
  assign trap    = trap_hit(q);
  assign fix_val = entry_state();
endmodule

// File: rtl/jc_phase_decode.sv
module jc_phase_decode
  import jc_pkg::*;
(
  input  ring_t  q,
  output phase_t hot
);
  for (genvar k = 0; k < int'(JC_PHASES); k++) begin : g_ph
    if (k == 0) begin : g_zero
      assign hot[k] = ~q[0] & ~q[JC_N-1];
    end else if (k < int'(JC_N)) begin : g_fill
      assign hot[k] = q[k-1] & ~q[k];
    end else if (k == int'(JC_N)) begin : g_full
      assign hot[k] = q[0] & q[JC_N-1];
    end else begin : g_drain
      assign hot[k] = ~q[k-JC_N-1] & q[k-JC_N];
    end
  end
endmodule

// File: rtl/jc_twisted_ring.sv
module jc_twisted_ring
  import jc_pkg::*;
#(
  parameter ring_t START = '0
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] stage_q,
  output logic [7:0] phase_hot
);
  ring_t  q;
  logic   trap;
  ring_t  fix_val;
  phase_t hot;
  logic   legal_now;
  logic [2:0] off_run;

  jc_trap_detect u_trap (.q(q), .trap(trap), .fix_val(fix_val));

  jc_stage_chain #(.START(START)) u_chain (
    .clk(clk), .rst(rst), .load_en(trap), .load_val(fix_val), .q(q)
  );

  jc_phase_decode u_dec (.q(q), .hot(hot));

  assign stage_q   = q;
  assign phase_hot = hot;
  assign legal_now = in_cycle(q);

  // consecutive cycles spent off the legal cycle, saturating
  always_ff @(posedge clk) begin
    if (rst)             off_run <= '0;
    else if (legal_now)  off_run <= '0;
    else if (off_run != 3'd7) off_run <= off_run + 3'd1;
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (stage_q == START));
  assert_twist_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !trap |=> (stage_q[0] == !$past(stage_q[3]) && stage_q[3:1] == $past(stage_q[2:0])));
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    legal_now |=> ($countones(stage_q ^ $past(stage_q)) == 1));
  assert_trap_entry_R5: assert property (@(posedge clk) disable iff (rst)
    trap |=> (stage_q == 4'b0001));
  assert_stays_legal_R6: assert property (@(posedge clk) disable iff (rst)
    legal_now |=> legal_now);
  assert_recover_bound_R6: assert property (@(posedge clk) disable iff (rst)
    off_run <= 3'd3);
  assert_onehot_legal_R8: assert property (@(posedge clk) disable iff (rst)
    legal_now |-> ($countones(phase_hot) == 1));
endmodule

// File: tb/sim_jc_twisted_ring.sv
module sim_jc_twisted_ring;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  logic [3:0] q0;
  logic [7:0] h0;
  jc_twisted_ring u0 (.clk(clk), .rst(rst), .stage_q(q0), .phase_hot(h0));

  logic [3:0] qs [16];
  logic [7:0] hs [16];
  for (genvar g = 0; g < 16; g++) begin : g_start
    jc_twisted_ring #(.START(4'(g))) u_s (
      .clk(clk), .rst(rst), .stage_q(qs[g]), .phase_hot(hs[g]));
  end

  // bench views: bit 0 = Qa
  function automatic logic [3:0] pat_of(input int p);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = (p <= 4) ? (b < p) : (b >= p - 4);
    return r;
  endfunction

  function automatic int phase_of(input logic [3:0] s);
    for (int p = 0; p < 8; p++) if (pat_of(p) == s) return p;
    return -1;
  endfunction

  function automatic logic [3:0] model_next(input logic [3:0] s);
    if (!s[0] && !s[3]) return 4'b0001;
    return {s[2:0], ~s[3]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int         ph;
  logic [3:0] prev0;
  logic [3:0] mdl [16];
  int         off [16];

  task automatic step(input logic r);
    rst = r;
    @(negedge clk);
    prev0 = pat_of(ph);
    ph = r ? 0 : (ph + 1) % 8;
    chk(r ? "R9 main reset" : "R3 main sequence", q0, pat_of(ph));
    chk("R7 phase line", h0, 8'(1) << ph);
    chk("R8 one hot", $countones(h0), 1);
    if (!r) chk("R4 one-bit step", $countones(q0 ^ prev0), 1);
    for (int g = 0; g < 16; g++) begin
      mdl[g] = r ? 4'(g) : model_next(mdl[g]);
      chk(r ? "R1 start load" : "R2 R5 next state", qs[g], mdl[g]);
      if (r || phase_of(qs[g]) >= 0) off[g] = 0;
      else off[g]++;
      if (!r && off[g] > 3) chk("R6 recovery bound", off[g], 3);
      if (phase_of(qs[g]) >= 0)
        chk("R8 legal one hot", hs[g], 8'(1) << phase_of(qs[g]));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    ph = 0;
    for (int g = 0; g < 16; g++) begin mdl[g] = 4'(g); off[g] = 0; end
    step(1'b1);
    step(1'b1);
    chk("R1 reset state", q0, 4'b0000);
    chk("R7 reset phase", h0, 8'b0000_0001);
    // directed: two full laps, illegal starts recover
    for (int i = 0; i < 16; i++) step(1'b0);
    // directed: reset at several phases
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < i; j++) step(1'b0);
      step(1'b1);
    end
    // random reset pulses
    for (int i = 0; i < 3000; i++) step(($urandom % 13) == 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule